// File: doc/BRIEF.md
# SPI Host Transaction Sequencer

This block sits on the host side of an SPI link to a peripheral controller. It decides, transaction by transaction, whether to read from the peripheral or to write to it. Every transaction is half-duplex. Chip select is raised, one command byte is clocked out, one status byte is clocked back, and a data phase follows whose length comes from that status byte. Chip select then drops and the next decision is made. Byte shifting is delegated to an external shifter through a start/done handshake, one byte per handshake. The peripheral's ready line tells the sequencer when a read is possible.

Outgoing data is a byte stream that the sequencer pulls with a take strobe, after a total length has been loaded. Writes are split into chunks no larger than the free space that the peripheral reports, and a done pulse is given once the whole length has gone out. Incoming data is collected in a staging buffer during the data phase. Only after the phase ends is it copied into a local receive FIFO, which the consumer drains through a first-word-fall-through pop interface.

Top module: `spiHostSeq`

## Requirements
- R1: A read sends command byte 0x81 and a write sends 0x42. Each is exactly one shifter byte, and the status byte that follows is clocked with fill byte 0x00 on the outgoing side.
- R2: `csAct` is 0 after reset. It stays 1 from the command byte through the last data byte, drops after each transaction, and every `xferStart` occurs while it is 1.
- R3: In a read, the status value N (when N ≤ 64) is the exact number of data bytes clocked in. None of them becomes visible on `rxValid` before `csAct` has dropped.
- R4: A read status above 64 is clamped to 64 data bytes and produces a one-cycle `statErr` pulse.
- R5: In a write, the chunk length is the minimum of the remaining length, the status value and 64. A status of 0 ends the transaction with no data byte, and the write is retried in a later transaction.
- R6: At each decision point a read wins when `periphReady` is 1 and the FIFO has at least 64 free entries. Otherwise a write starts if bytes remain. Otherwise the block keeps re-evaluating both conditions every cycle.
- R7: A write raises `csAct` first and sends its command only once `periphReady` is 1. A read command is only sent when `periphReady` was already 1.
- R8: Outgoing data bytes appear in stream order, one `txTake` per data byte. `txDone` pulses for one cycle, in the cycle in which `csAct` drops after the chunk that brings the remaining length to zero, and at no other time.
- R9: An `xferDone` pulse that arrives while no byte is outstanding has no effect: no chip select and no start follow from it.
- R10: `txLoad` is accepted only when the remaining length is zero. A load during a pending write does not change the number of bytes sent.
- R11: The receive FIFO holds 128 bytes and keeps arrival order. No read starts while fewer than 64 entries are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| periphReady | input | 1 | Peripheral ready line |
| csAct | output | 1 | Chip select, 1 = selected |
| xferStart | output | 1 | One-cycle request to shift one byte |
| xferTxByte | output | 8 | Byte to shift out |
| xferRxByte | input | 8 | Byte shifted in, valid with xferDone |
| xferDone | input | 1 | One-cycle byte completion from the shifter |
| txLoad | input | 1 | Load a new outgoing length |
| txLen | input | LEN_W | Outgoing length in bytes |
| txByte | input | 8 | Current outgoing stream byte |
| txTake | output | 1 | Consume txByte |
| txDone | output | 1 | Whole outgoing length sent |
| rxValid | output | 1 | Receive FIFO not empty |
| rxData | output | 8 | Head of the receive FIFO |
| rxPop | input | 1 | Remove the FIFO head |
| statErr | output | 1 | Read status exceeded the data-phase limit |

## Verification
The bench plays the peripheral and the shifter from a behavioural queue model. It scripts status replies and checks every byte against the model. Short reads, an oversize read status, and a chunked write with a zero-status abort in the middle show the two status meanings apart. A write held off by a low ready line separates the select-then-wait ordering from the read path. A read queued in the same cycle as a write load exposes the priority. Filling the FIFO with two full reads shows the space gate holding a third read until the consumer drains. A stray done pulse while idle and a reload during a busy write cover the inputs that must be ignored.

// File: rtl/spiSeqPkg.sv
package spiSeqPkg;
  localparam logic [7:0] CMD_READ  = 8'h81;
  localparam logic [7:0] CMD_WRITE = 8'h42;
  localparam logic [7:0] FILL_BYTE = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TXWAIT, ST_CMD, ST_STAT, ST_DATA, ST_COPY
  } seqState_t;

  typedef enum logic [1:0] {
    SRC_RDCMD, SRC_WRCMD, SRC_FILL, SRC_TX
  } byteSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     issue;     // launch one shifter byte
    byteSrc_t src;       // what that byte is
    logic     isRead;    // current transaction direction
    logic     takeStat;  // status byte arrived
    logic     dataStep;  // one data byte finished
    logic     endChunk;  // data phase finished
    logic     copyPush;  // move one staged byte into the FIFO
    logic     clrIdx;    // reset byte index
  } seqStrobe_t;
endpackage

// File: rtl/spiSeqData.sv
module spiSeqData
  import spiSeqPkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int CHUNK_MAX  = 64,
  parameter int FIFO_DEPTH = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             txLoad,
  input  logic [LEN_W-1:0] txLen,
  input  logic [7:0]       txByte,
  input  logic [7:0]       xferRxByte,
  input  logic             rxPop,
  output logic             xferStart,
  output logic [7:0]       xferTxByte,
  output logic             txTake,
  output logic             txDone,
  output logic             statErr,
  output logic             rxValid,
  output logic [7:0]       rxData,
  output logic             remainZero,
  output logic             spaceOk,
  output logic             statZero,
  output logic             lastStep
);
  localparam int IDX_W = $clog2(CHUNK_MAX + 1);
  localparam int SAW   = $clog2(CHUNK_MAX);
  localparam int FAW   = $clog2(FIFO_DEPTH);
  localparam int CNT_W = FAW + 1;

  logic [LEN_W-1:0] remain;
  logic [IDX_W-1:0] chunk, idx, statChunkC;
  logic             statOver;
  logic [31:0]      lim;
  logic [7:0]       stage [CHUNK_MAX];
  logic [7:0]       fifoMem [FIFO_DEPTH];
  logic [FAW-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [7:0]       byteSel, byteOutQ;
  logic             startQ, txDoneQ, statErrQ, doPop;

  // data-phase length from the status byte
  always_comb begin
    statOver = 1'b0;
    if (strobe.isRead) begin
      lim      = 32'(xferRxByte);
      statOver = lim > 32'(CHUNK_MAX);
    end else begin
      lim = (32'(remain) < 32'(xferRxByte)) ? 32'(remain) : 32'(xferRxByte);
    end
    if (lim > 32'(CHUNK_MAX)) lim = 32'(CHUNK_MAX);
    statChunkC = IDX_W'(lim);
  end

  assign statZero   = (statChunkC == '0);
  assign lastStep   = (IDX_W'(idx + 1'b1) == chunk);
  assign remainZero = (remain == '0);
  assign spaceOk    = (count <= CNT_W'(FIFO_DEPTH - CHUNK_MAX));

  always_comb begin
    unique case (strobe.src)
      SRC_RDCMD: byteSel = CMD_READ;
      SRC_WRCMD: byteSel = CMD_WRITE;
      SRC_FILL:  byteSel = FILL_BYTE;
      default:   byteSel = txByte;
    endcase
  end

  assign txTake     = strobe.issue && (strobe.src == SRC_TX);
  assign xferStart  = startQ;
  assign xferTxByte = byteOutQ;
  assign txDone     = txDoneQ;
  assign statErr    = statErrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain   <= '0;
      chunk    <= '0;
      idx      <= '0;
      startQ   <= 1'b0;
      byteOutQ <= '0;
      txDoneQ  <= 1'b0;
      statErrQ <= 1'b0;
    end else begin
      startQ <= strobe.issue;
      if (strobe.issue) byteOutQ <= byteSel;
      if (strobe.takeStat) chunk <= statChunkC;
      statErrQ <= strobe.takeStat && statOver;
      if (strobe.clrIdx) idx <= '0;
      else if (strobe.dataStep || strobe.copyPush) idx <= idx + 1'b1;
      if (txLoad && remainZero) remain <= txLen;
      else if (strobe.endChunk && !strobe.isRead) remain <= remain - LEN_W'(chunk);
      txDoneQ <= strobe.endChunk && !strobe.isRead && (remain == LEN_W'(chunk));
    end
  end

  // staging buffer, filled during the data phase
  always_ff @(posedge clk) begin
    if (strobe.dataStep && strobe.isRead) stage[idx[SAW-1:0]] <= xferRxByte;
  end

  // receive FIFO
  assign doPop   = rxPop && (count != '0);
  assign rxValid = (count != '0);
  assign rxData  = fifoMem[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.copyPush) fifoMem[wrPtr] <= stage[idx[SAW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.copyPush) wrPtr <= wrPtr + 1'b1;
      if (doPop) rdPtr <= rdPtr + 1'b1;
      unique case ({strobe.copyPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spiSeqCtrl.sv
module spiSeqCtrl
  import spiSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       periphReady,
  input  logic       xferDone,
  input  logic       remainZero,
  input  logic       spaceOk,
  input  logic       statZero,
  input  logic       lastStep,
  output seqStrobe_t strobe,
  output logic       csAct
);
  seqState_t state, stateNext;
  logic readQ, readNext, waitQ, csQ, csSet, csClr, dn;

  // a done only counts while a byte is outstanding
  assign dn    = xferDone && waitQ;
  assign csAct = csQ;

  always_comb begin
    stateNext     = state;
    readNext      = readQ;
    csSet         = 1'b0;
    csClr         = 1'b0;
    strobe        = '0;
    strobe.src    = SRC_FILL;
    strobe.isRead = readQ;
    unique case (state)
      ST_IDLE: begin
        if (periphReady && spaceOk) begin
          csSet        = 1'b1;
          readNext     = 1'b1;
          strobe.issue = 1'b1;
          strobe.src   = SRC_RDCMD;
          stateNext    = ST_CMD;
        end else if (!remainZero) begin
          csSet     = 1'b1;
          readNext  = 1'b0;
          stateNext = ST_TXWAIT;
        end
      end
      ST_TXWAIT: begin
        if (periphReady) begin
          strobe.issue = 1'b1;
          strobe.src   = SRC_WRCMD;
          stateNext    = ST_CMD;
        end
      end
      ST_CMD: begin
        if (dn) begin
          strobe.issue = 1'b1;
          strobe.src   = SRC_FILL;
          stateNext    = ST_STAT;
        end
      end
      ST_STAT: begin
        if (dn) begin
          strobe.takeStat = 1'b1;
          strobe.clrIdx   = 1'b1;
          if (statZero) begin
            csClr     = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            strobe.issue = 1'b1;
            strobe.src   = readQ ? SRC_FILL : SRC_TX;
            stateNext    = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (dn) begin
          strobe.dataStep = 1'b1;
          if (lastStep) begin
            strobe.endChunk = 1'b1;
            csClr           = 1'b1;
            if (readQ) begin
              strobe.clrIdx = 1'b1;
              stateNext     = ST_COPY;
            end else begin
              stateNext = ST_IDLE;
            end
          end else begin
            strobe.issue = 1'b1;
            strobe.src   = readQ ? SRC_FILL : SRC_TX;
          end
        end
      end
      ST_COPY: begin
        strobe.copyPush = 1'b1;
        if (lastStep) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      readQ <= 1'b0;
      waitQ <= 1'b0;
      csQ   <= 1'b0;
    end else begin
      state <= stateNext;
      readQ <= readNext;
      if (strobe.issue) waitQ <= 1'b1;
      else if (dn) waitQ <= 1'b0;
      if (csSet) csQ <= 1'b1;
      else if (csClr) csQ <= 1'b0;
    end
  end
endmodule

// File: rtl/spiHostSeq.sv
module spiHostSeq
  import spiSeqPkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int CHUNK_MAX  = 64,
  parameter int FIFO_DEPTH = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periphReady,
  output logic             csAct,
  output logic             xferStart,
  output logic [7:0]       xferTxByte,
  input  logic [7:0]       xferRxByte,
  input  logic             xferDone,
  input  logic             txLoad,
  input  logic [LEN_W-1:0] txLen,
  input  logic [7:0]       txByte,
  output logic             txTake,
  output logic             txDone,
  output logic             rxValid,
  output logic [7:0]       rxData,
  input  logic             rxPop,
  output logic             statErr
);
  seqStrobe_t strobe;
  logic remainZero, spaceOk, statZero, lastStep;

  spiSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .periphReady(periphReady), .xferDone(xferDone),
    .remainZero(remainZero), .spaceOk(spaceOk), .statZero(statZero),
    .lastStep(lastStep), .strobe(strobe), .csAct(csAct)
  );

  spiSeqData #(.LEN_W(LEN_W), .CHUNK_MAX(CHUNK_MAX), .FIFO_DEPTH(FIFO_DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txLoad(txLoad), .txLen(txLen),
    .txByte(txByte), .xferRxByte(xferRxByte), .rxPop(rxPop),
    .xferStart(xferStart), .xferTxByte(xferTxByte), .txTake(txTake),
    .txDone(txDone), .statErr(statErr), .rxValid(rxValid), .rxData(rxData),
    .remainZero(remainZero), .spaceOk(spaceOk), .statZero(statZero),
    .lastStep(lastStep)
  );
endmodule

// File: rtl/spiHostSeqChk.sv
module spiHostSeqChk (
  input logic clk,
  input logic rstN,
  input logic periphReady,
  input logic csAct,
  input logic xferStart,
  input logic txTake,
  input logic txDone,
  input logic statErr
);
  // R2
  cs_with_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> csAct);

  // R8
  take_in_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    txTake |-> csAct);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone);

  // R4
  stat_err_in_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    statErr |-> csAct);

  // R7
  read_needs_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(csAct) && xferStart) |-> $past(periphReady));
endmodule

bind spiHostSeq spiHostSeqChk uChk (
  .clk(clk), .rstN(rstN), .periphReady(periphReady), .csAct(csAct),
  .xferStart(xferStart), .txTake(txTake), .txDone(txDone), .statErr(statErr)
);

// File: tb/tb_spiHostSeq.sv
module tb_spiHostSeq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic periphReady = 1'b0, xferDone = 1'b0, txLoad = 1'b0, rxPop = 1'b0;
  logic [7:0] xferRxByte = 8'h00;
  logic [15:0] txLen = 16'h0;
  logic csAct, xferStart, txTake, txDone, rxValid, statErr;
  logic [7:0] xferTxByte, txByte, rxData;

  logic [7:0] txSrc [256];
  logic [7:0] txPos;
  assign txByte = txSrc[txPos];

  spiHostSeq dut (
    .clk(clk), .rstN(rstN), .periphReady(periphReady), .csAct(csAct),
    .xferStart(xferStart), .xferTxByte(xferTxByte), .xferRxByte(xferRxByte),
    .xferDone(xferDone), .txLoad(txLoad), .txLen(txLen), .txByte(txByte),
    .txTake(txTake), .txDone(txDone), .rxValid(rxValid), .rxData(rxData),
    .rxPop(rxPop), .statErr(statErr)
  );

  always @(posedge clk) begin
    if (!rstN) txPos <= 8'h0;
    else if (txTake) txPos <= txPos + 8'h1;
  end

  int errs = 0, checks = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // peripheral / shifter model
  int rdStatQ[$], wrStatQ[$], expRx[$];
  int modelRemain = 0, phase = 0, n = 0, cnt = 0, rdVal = 16, wrPos = 0;
  int doneCnt = 0, strayReq = 0, strayAck = 0;
  int txDones = 0, statErrs = 0, errExp = 0, rdCmds = 0, starts = 0;
  bit isRd = 1'b0, holdWr = 1'b0, prevCs = 1'b0, fifoWasEmpty = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      if (doneCnt == 1) begin
        xferDone = 1'b1; doneCnt = 0;
      end else begin
        xferDone = 1'b0;
        if (doneCnt > 1) doneCnt--;
        else if (strayReq != strayAck) begin
          xferDone = 1'b1; strayAck = strayReq;
        end
      end
      if (txDone) txDones++;
      if (statErr) statErrs++;
      if (xferStart) begin
        starts++;
        chk(csAct, "R2 start outside chip select", int'(csAct), 1);
        if (phase == 0) begin
          isRd = (xferTxByte == 8'h81);
          chk(isRd || xferTxByte == 8'h42, "R1 command byte", xferTxByte, 8'h42);
          if (isRd) begin
            rdCmds++;
            fifoWasEmpty = !rxValid;
            chk(rdStatQ.size() > 0, "R7 read without ready", 0, 1);
          end else begin
            chk(rdStatQ.size() == 0, "R6 write chosen over ready read", rdStatQ.size(), 0);
          end
          phase = 1;
          xferRxByte = 8'h00;
        end else if (phase == 1) begin
          int s;
          chk(xferTxByte == 8'h00, "R1 status fill byte", xferTxByte, 0);
          if (isRd) begin
            s = (rdStatQ.size() > 0) ? rdStatQ.pop_front() : 0;
            n = (s > 64) ? 64 : s;
            if (s > 64) errExp++;
          end else begin
            s = (wrStatQ.size() > 0) ? wrStatQ.pop_front() : 255;
            n = (modelRemain < s) ? modelRemain : s;
            if (n > 64) n = 64;
          end
          xferRxByte = 8'(s);
          phase = 2;
          cnt = 0;
        end else begin
          chk(cnt < n, "R3 R5 data phase too long", cnt + 1, n);
          if (isRd) begin
            xferRxByte = 8'(rdVal);
            expRx.push_back(rdVal);
            rdVal = (rdVal + 1) & 255;
            if (fifoWasEmpty) chk(!rxValid, "R3 early FIFO data", int'(rxValid), 0);
          end else begin
            chk(xferTxByte == txSrc[wrPos & 255], "R8 write byte order",
                xferTxByte, txSrc[wrPos & 255]);
            wrPos++;
          end
          cnt++;
        end
        doneCnt = 2;
      end
      if (prevCs && !csAct) begin
        chk(cnt == n, "R2 release before data complete", cnt, n);
        if (!isRd) begin
          bit expDone;
          modelRemain -= cnt;
          expDone = (cnt > 0) && (modelRemain == 0);
          chk(txDone == expDone, "R8 done pulse at release", int'(txDone), int'(expDone));
        end else if (fifoWasEmpty) begin
          chk(!rxValid, "R3 FIFO data before copy", int'(rxValid), 0);
        end
        phase = 0; n = 0; cnt = 0;
      end else if (txDone) begin
        chk(1'b0, "R8 done pulse outside release", 1, 0);
      end
      prevCs = csAct;
      periphReady = (rdStatQ.size() > 0) || (csAct && phase == 0 && !holdWr);
    end
  end

  task automatic quiet(input int need);
    int q = 0;
    while (q < need) begin
      @(negedge clk);
      if (!csAct && rdStatQ.size() == 0 && modelRemain == 0 && doneCnt == 0) q++;
      else q = 0;
    end
  endtask

  task automatic drain();
    while (expRx.size() > 0 || rdStatQ.size() > 0 || csAct) begin
      @(negedge clk);
      if (rxValid && expRx.size() > 0) begin
        chk(rxData == 8'(expRx[0]), "R11 FIFO order", rxData, expRx[0]);
        void'(expRx.pop_front());
        rxPop = 1'b1;
      end else begin
        rxPop = 1'b0;
      end
    end
    @(negedge clk);
    rxPop = 1'b0;
  endtask

  task automatic loadTx(input int len, input bit accept);
    @(negedge clk);
    txLoad = 1'b1;
    txLen = 16'(len);
    if (accept) modelRemain += len;
    @(negedge clk);
    txLoad = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int w0, d0, s0, r0;
    for (int i = 0; i < 256; i++) txSrc[i] = 8'((i * 7 + 3) & 255);
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(!csAct && !xferStart && !txDone && !statErr && !rxValid, "R2 reset state",
        int'({csAct, xferStart, txDone, statErr, rxValid}), 0);
    rstN = 1'b1;

    // R3 short read
    rdStatQ.push_back(5);
    quiet(10);
    chk(expRx.size() == 5, "R3 read byte count", expRx.size(), 5);
    drain();

    // R4 oversize read status
    rdStatQ.push_back(70);
    quiet(10);
    chk(expRx.size() == 64, "R4 clamped read length", expRx.size(), 64);
    chk(statErrs == errExp && errExp == 1, "R4 status error pulse", statErrs, 1);
    drain();

    // R5 chunked write with a zero-space abort
    w0 = wrPos; d0 = txDones;
    wrStatQ = '{4, 0, 100};
    loadTx(10, 1'b1);
    quiet(10);
    chk(wrPos - w0 == 10, "R5 chunked write total", wrPos - w0, 10);
    chk(txDones - d0 == 1, "R5 single completion", txDones - d0, 1);

    // R7 write waits for ready after select
    holdWr = 1'b1;
    wrStatQ = '{8};
    loadTx(3, 1'b1);
    s0 = starts;
    repeat (30) @(negedge clk);
    chk(csAct, "R7 select held while waiting", int'(csAct), 1);
    chk(starts == s0, "R7 no command before ready", starts - s0, 0);
    holdWr = 1'b0;
    quiet(10);
    chk(txDones - d0 == 2, "R7 held write completes", txDones - d0, 2);

    // R10 reload during a pending write is ignored
    w0 = wrPos; d0 = txDones;
    wrStatQ = '{2, 2, 2};
    loadTx(6, 1'b1);
    while (!csAct) @(negedge clk);
    loadTx(20, 1'b0);
    quiet(10);
    chk(wrPos - w0 == 6, "R10 reload ignored", wrPos - w0, 6);
    chk(txDones - d0 == 1, "R10 one completion", txDones - d0, 1);

    // R6 read and write pending together: read first
    r0 = rdCmds; w0 = wrPos;
    @(negedge clk);
    rdStatQ.push_back(3);
    wrStatQ = '{5};
    txLoad = 1'b1; txLen = 16'd2; modelRemain += 2;
    @(negedge clk);
    txLoad = 1'b0;
    quiet(10);
    chk(rdCmds - r0 == 1, "R6 read served", rdCmds - r0, 1);
    chk(wrPos - w0 == 2, "R6 write served after read", wrPos - w0, 2);
    drain();

    // R11 FIFO space gate
    r0 = rdCmds;
    rdStatQ.push_back(64); rdStatQ.push_back(64); rdStatQ.push_back(10);
    repeat (1500) @(negedge clk);
    chk(rdCmds - r0 == 2, "R11 read blocked when FIFO full", rdCmds - r0, 2);
    chk(!csAct && rxValid, "R11 idle with full FIFO", int'({csAct, rxValid}), 1);
    drain();
    chk(rdCmds - r0 == 3, "R11 read resumes after drain", rdCmds - r0, 3);

    // R9 stray done while idle
    s0 = starts;
    strayReq++;
    repeat (12) @(negedge clk);
    chk(!csAct && starts == s0, "R9 stray done ignored", starts - s0, 0);
    rdStatQ.push_back(2);
    quiet(10);
    chk(expRx.size() == 2, "R9 read after stray done", expRx.size(), 2);
    drain();

    chk(statErrs == errExp, "R4 error pulse total", statErrs, errExp);
    finishRun();
  end
endmodule